// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Tag-Checked Flush

This block sits between a processor's load path and main memory and answers word reads from a small direct-mapped store. There are eight lines, each holding one 32-bit word, an address tag and a valid flag. A read addresses exactly one line through the index bits. The block compares the stored tag with the upper address bits and answers from the line when the tag matches and the line is valid. Otherwise it fetches the word from memory over a request/acknowledge port, fills the line and returns the fetched word.

A flush input names an address. The line that address indexes is marked empty only when it holds that same address. Software uses this after memory has been changed behind the cache, for example by a device transfer. Index bits are never stored, so each entry needs only 60 bits. A debug port rebuilds the full word address held by any line from its tag and its own index.

The controller has four named states. IDLE waits for work and performs flushes. LOOKUP compares tags. FETCH holds a memory request until it is acknowledged. RESPOND returns fetched data. The transitions are:
- IDLE→LOOKUP on a read request.
- LOOKUP→IDLE on a hit.
- LOOKUP→FETCH on a miss.
- FETCH→RESPOND on acknowledge.
- RESPOND→IDLE unconditionally.

Top module: `dm_word_cache`

## Requirements
- R1: After reset every line reads as empty: the debug valid output is 0 for all eight lines, and the first read of any address misses.
- R2: Address bits [1:0] take no part in lookup. The line index is bits [4:2] and the tag is bits [31:5]. The memory request address is the read address with bits [1:0] forced to 0.
- R3: A read whose indexed line is valid and holds the same tag is a hit. On a hit, cpu_ready is 1 in the cycle after the request cycle with the stored word on cpu_rdata, and no memory request is made.
- R4: A read whose line is empty or holds another tag is a miss. mem_req is raised with a steady address until mem_ack. cpu_ready is then 1 in the cycle after the acknowledge cycle, with the word from mem_rdata.
- R5: A fill writes the tag and data of the indexed line and sets its valid bit, so the same address hits afterwards.
- R6: A flush whose address matches the tag of its indexed valid line clears that line's valid bit, so the next read of that address misses and fetches fresh data.
- R7: A flush whose address carries a different tag than its indexed line leaves the line valid, and that line keeps returning its stored word.
- R8: flush_req is acted on only in IDLE. A flush presented during LOOKUP, FETCH or RESPOND leaves every line unchanged.
- R9: When flush_req and cpu_req are both presented in IDLE, the flush takes effect before the lookup, so a read of the flushed address misses.
- R10: For the line selected by dbg_line, dbg_addr equals {stored tag, dbg_line, 2'b00}. For example, tag 0x2C0 in line 1 gives 0x0000_5804.
- R11: Consecutive words occupy distinct lines and can all be held at once. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| cpu_req | input | 1 | Read request, sampled in IDLE |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_ready | output | 1 | One-cycle pulse: read data valid |
| cpu_rdata | output | 32 | Read data word |
| flush_req | input | 1 | Flush request, sampled in IDLE |
| flush_addr | input | 32 | Address whose line is to be invalidated on tag match |
| mem_req | output | 1 | Memory fetch request, held until acknowledged |
| mem_addr | output | 32 | Word-aligned fetch address |
| mem_ack | input | 1 | Memory acknowledge, data valid on mem_rdata |
| mem_rdata | input | 32 | Fetched word |
| dbg_line | input | 3 | Line selected for inspection |
| dbg_valid | output | 1 | Valid bit of the selected line |
| dbg_addr | output | 32 | Word address rebuilt from the selected line's tag and index |

## Verification
Reads are issued in several patterns:
- A repeat of a filled address, and the same word with a different byte offset. These separate a true tag hit from a refetch, and show that the offset is ignored.
- A run of consecutive words followed by a read of an older address with the same index. This separates distinct-line placement from conflict eviction.

Flushes are issued in four ways:
- With a matching address.
- With a non-matching tag on a valid line.
- While a slow fetch is in progress.
- In the same cycle as a read of that address.

The backing memory's contents are changed between phases, so a stale hit returns different data from a correct refetch. The debug port confirms valid bits and rebuilt addresses directly.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOOKUP  = 2'd1,
        ST_FETCH   = 2'd2,
        ST_RESPOND = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_line_store.sv
`timescale 1ns/1ps
module dmc_line_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 27,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inval_en,
    input  logic [IDX_W-1:0]  inval_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              peek_valid,
    output logic [TAG_W-1:0]  peek_tag
);

    logic              valid_w [LINES];
    logic [TAG_W-1:0]  tag_w   [LINES];
    logic [DATA_W-1:0] data_w  [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              wr_hit;
        logic              clr_hit;

        assign wr_hit  = fill_en  && (fill_idx  == IDX_W'(i));
        assign clr_hit = inval_en && (inval_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (wr_hit) begin
                v_q <= 1'b1;
            end else if (clr_hit) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_hit) begin
                t_q <= fill_tag;
                d_q <= fill_data;
            end
        end

        assign valid_w[i] = v_q;
        assign tag_w[i]   = t_q;
        assign data_w[i]  = d_q;
    end

    assign rd_valid   = valid_w[rd_idx];
    assign rd_tag     = tag_w[rd_idx];
    assign rd_data    = data_w[rd_idx];
    assign peek_valid = valid_w[peek_idx];
    assign peek_tag   = tag_w[peek_idx];

endmodule

// File: rtl/dmc_tag_match.sv
`timescale 1ns/1ps
module dmc_tag_match #(
    parameter int TAG_W = 27
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);

    assign hit = line_valid && (line_tag == probe_tag);

endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flush_req,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              hit,
    input  logic [DATA_W-1:0] line_data,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              inval_en,
    output dmc_state_e        state
);

    localparam int IDX_LO = OFS_W;
    localparam int TAG_LO = OFS_W + IDX_W;

    dmc_state_e        state_q;
    dmc_state_e        state_d;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] resp_data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request address and fetched word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            resp_data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                req_addr_q <= cpu_addr;
            end
            if (state_q == ST_FETCH && mem_ack) begin
                resp_data_q <= mem_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = hit ? ST_IDLE : ST_FETCH;
            ST_FETCH:   if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        mem_req   = 1'b0;
        mem_addr  = {req_addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        fill_en   = 1'b0;
        inval_en  = 1'b0;
        look_idx  = req_addr_q[TAG_LO-1:IDX_LO];
        look_tag  = req_addr_q[ADDR_W-1:TAG_LO];
        unique case (state_q)
            ST_IDLE: begin
                look_idx = flush_addr[TAG_LO-1:IDX_LO];
                look_tag = flush_addr[ADDR_W-1:TAG_LO];
                inval_en = flush_req && hit;
            end
            ST_LOOKUP: begin
                cpu_ready = hit;
                cpu_rdata = hit ? line_data : '0;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
                cpu_rdata = resp_data_q;
            end
            default: ;
        endcase
    end

    assign fill_idx = req_addr_q[TAG_LO-1:IDX_LO];
    assign fill_tag = req_addr_q[ADDR_W-1:TAG_LO];
    assign state    = state_q;

endmodule

// File: rtl/dm_word_cache.sv
`timescale 1ns/1ps
module dm_word_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    localparam int OFS_W = $clog2(DATA_W / 8),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flush_req,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  dbg_line,
    output logic              dbg_valid,
    output logic [ADDR_W-1:0] dbg_addr
);

    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              hit;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              inval_en;
    logic [TAG_W-1:0]  peek_tag;
    dmc_state_e        cur_state;

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .flush_req  (flush_req),
        .flush_addr (flush_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .look_idx   (look_idx),
        .look_tag   (look_tag),
        .hit        (hit),
        .line_data  (line_data),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .inval_en   (inval_en),
        .state      (cur_state)
    );

    dmc_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_data  (mem_rdata),
        .inval_en   (inval_en),
        .inval_idx  (look_idx),
        .rd_idx     (look_idx),
        .rd_valid   (line_valid),
        .rd_tag     (line_tag),
        .rd_data    (line_data),
        .peek_idx   (dbg_line),
        .peek_valid (dbg_valid),
        .peek_tag   (peek_tag)
    );

    dmc_tag_match #(
        .TAG_W (TAG_W)
    ) u_match (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .probe_tag  (look_tag),
        .hit        (hit)
    );

    // full word address rebuilt from stored tag and the line's own index
    assign dbg_addr = {peek_tag, dbg_line, {OFS_W{1'b0}}};

endmodule

// File: rtl/dmc_checker.sv
`timescale 1ns/1ps
module dmc_checker
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input dmc_state_e        state
);

    // R3: a hit answers without touching memory
    p_ready_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R3: each answer is a single-cycle pulse
    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4: request held with a steady address until acknowledged
    p_memreq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: answer follows the acknowledge cycle
    p_ack_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> cpu_ready);

    // R2: fetch address is word aligned
    p_mem_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9: a request in IDLE always proceeds to lookup, flush or not
    p_req_to_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req) |=> (state == ST_LOOKUP));

endmodule

bind dm_word_cache dmc_checker #(.ADDR_W(ADDR_W)) u_dmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .state     (cur_state)
);

// File: tb/dm_word_cache_bench.sv
`timescale 1ns/1ps
module dm_word_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        flush_req = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  dbg_line = '0;
    logic        dbg_valid;
    logic [31:0] dbg_addr;

    int checks = 0;
    int errors = 0;
    int fetch_cnt = 0;
    int mem_lat = 0;
    int wait_cnt = 0;
    logic [7:0]  gen = 8'd0;
    logic [31:0] last_mem_addr = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dm_word_cache u_dm_word_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .flush_addr(flush_addr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dbg_line(dbg_line), .dbg_valid(dbg_valid), .dbg_addr(dbg_addr)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [7:0] g);
        return (a ^ 32'h1357_9BDF) ^ {g, 24'h0};
    endfunction

    // backing memory model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_ack = 1'b1;
                mem_rdata = mem_word(mem_addr, gen);
                last_mem_addr = mem_addr;
                fetch_cnt++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read; optionally a flush in the same cycle
    task automatic do_read(input logic [31:0] a, input bit exp_hit, input logic [31:0] exp_data,
                           input string req, input bit with_flush = 1'b0,
                           input logic [31:0] faddr = '0);
        int cycles;
        int f0;
        f0 = fetch_cnt;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_addr = a;
        if (with_flush) begin
            flush_req = 1'b1;
            flush_addr = faddr;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        flush_req = 1'b0;
        cycles = 1;
        while (!cpu_ready && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        check(cpu_ready === 1'b1, {req, " ready"}, 32'(cpu_ready), 32'd1);
        check(cpu_rdata === exp_data, {req, " data"}, cpu_rdata, exp_data);
        if (exp_hit) begin
            check(cycles == 1, {req, " hit latency"}, 32'(cycles), 32'd1);
            check(fetch_cnt == f0, {req, " no fetch on hit"}, 32'(fetch_cnt - f0), 32'd0);
        end else begin
            check(cycles > 1, {req, " miss latency"}, 32'(cycles), 32'd2);
            check(fetch_cnt == f0 + 1, {req, " one fetch"}, 32'(fetch_cnt - f0), 32'd1);
            check(last_mem_addr === {a[31:2], 2'b00}, "R2 fetch address", last_mem_addr, {a[31:2], 2'b00});
        end
    endtask

    task automatic do_flush(input logic [31:0] a);
        @(negedge clk);
        flush_req = 1'b1;
        flush_addr = a;
        @(negedge clk);
        flush_req = 1'b0;
    endtask

    task automatic chk_line(input logic [2:0] idx, input bit exp_v, input logic [31:0] exp_a, input string req);
        dbg_line = idx;
        #0.5;
        check(dbg_valid === exp_v, {req, " line valid"}, 32'(dbg_valid), 32'(exp_v));
        if (exp_v) check(dbg_addr === exp_a, {req, " line address"}, dbg_addr, exp_a);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) chk_line(3'(i), 1'b0, '0, "R1 reset");
        do_read(32'h0000_00E8, 1'b0, mem_word(32'h0000_00E8, gen), "R1 first read misses");
    endtask

    task automatic t_hit_offset();
        chk_line(3'd2, 1'b1, 32'h0000_00E8, "R5 fill");
        do_read(32'h0000_00E8, 1'b1, mem_word(32'h0000_00E8, 8'd0), "R3 repeat hit");
        do_read(32'h0000_00EB, 1'b1, mem_word(32'h0000_00E8, 8'd0), "R2 offset ignored");
    endtask

    task automatic t_consecutive();
        do_read(32'h0000_5800, 1'b0, mem_word(32'h0000_5800, gen), "R4 miss line0");
        do_read(32'h0000_5804, 1'b0, mem_word(32'h0000_5804, gen), "R4 miss line1");
        do_read(32'h0000_5808, 1'b0, mem_word(32'h0000_5808, gen), "R11 miss line2 evicts");
        do_read(32'h0000_5800, 1'b1, mem_word(32'h0000_5800, gen), "R11 line0 kept");
        do_read(32'h0000_5804, 1'b1, mem_word(32'h0000_5804, gen), "R11 line1 kept");
        chk_line(3'd1, 1'b1, 32'h0000_5804, "R10 rebuilt address");
        do_read(32'h0000_00E8, 1'b0, mem_word(32'h0000_00E8, gen), "R11 conflict refetch");
        do_read(32'h0000_5808, 1'b0, mem_word(32'h0000_5808, gen), "R11 conflict back");
    endtask

    task automatic t_flush_match();
        gen = 8'd1;
        do_flush(32'h0000_5804);
        chk_line(3'd1, 1'b0, '0, "R6 flush match");
        do_read(32'h0000_5804, 1'b0, mem_word(32'h0000_5804, 8'd1), "R6 refetch fresh");
    endtask

    task automatic t_flush_nomatch();
        gen = 8'd2;
        do_flush(32'h0000_9804);
        chk_line(3'd1, 1'b1, 32'h0000_5804, "R7 flush other tag");
        do_read(32'h0000_5804, 1'b1, mem_word(32'h0000_5804, 8'd1), "R7 stored word kept");
    endtask

    task automatic t_flush_busy();
        int cycles;
        mem_lat = 3;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_addr = 32'h0000_7010;
        @(negedge clk);
        cpu_req = 1'b0;
        flush_req = 1'b1;
        flush_addr = 32'h0000_5800;
        cycles = 1;
        while (!cpu_ready && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        flush_req = 1'b0;
        check(cpu_rdata === mem_word(32'h0000_7010, gen), "R8 busy read data", cpu_rdata, mem_word(32'h0000_7010, gen));
        mem_lat = 0;
        @(negedge clk);
        chk_line(3'd0, 1'b1, 32'h0000_5800, "R8 flush ignored when busy");
    endtask

    task automatic t_flush_with_read();
        gen = 8'd3;
        do_read(32'h0000_5800, 1'b0, mem_word(32'h0000_5800, 8'd3), "R9 flush before lookup",
                1'b1, 32'h0000_5800);
        chk_line(3'd0, 1'b1, 32'h0000_5800, "R9 line refilled");
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_offset();
        t_consecutive();
        t_flush_match();
        t_flush_nomatch();
        t_flush_busy();
        t_flush_with_read();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule